// File: doc/BRIEF.md
# External Bus Ownership Arbiter

This block decides who owns a processor's external memory bus: the processor core or an outside bus master. The outside master raises an asynchronous request line. The arbiter passes that request through a flop chain to make it synchronous. It then lets any external access that the core already has under way run to completion. Only after that does it switch off the address, data and strobe drivers and raise the grant line. When the outside master drops its request, the arbiter hands the bus back to the core.

A mode input sets how the core behaves while the bus is away. With the mode low, the core is stalled for the whole time the grant is held. With the mode high, the core keeps running and is stalled only when it actually asks for an external access. In that case a hang flag also tells the system that the core is waiting for a bus it does not own. All pins are plain level signals. There is no data stream, so no valid/ready handshake is involved.

Top module: `bus_req_arb`

## Requirements
- R1: While `rst_n` is low, `bus_grant` is 0, `core_stall` and `grant_hang` are 0, and every driver enable is 1, so the core owns the bus.
- R2: `bus_req_async` is sampled by a chain of SYNC_STAGES flops. When `xfer_busy` is low, `bus_grant` rises on the clock edge after the synchronized request is seen. That is SYNC_STAGES+1 rising edges after the request was first sampled high.
- R3: If `xfer_busy` is high when the synchronized request is seen, the grant is held back. During the wait the drivers stay enabled and the core is not stalled. `bus_grant` rises on the first edge at which `xfer_busy` is sampled low.
- R4: Driver enables are active high, with 1 meaning drive and 0 meaning tri-state. `addr_oe`, `data_oe` and every bit of `strobe_oe` are 0 exactly while `bus_grant` is 1, and 1 otherwise.
- R5: With `go_mode` = 0, `core_stall` is 1 in every cycle in which `bus_grant` is 1.
- R6: With `go_mode` = 1 and `bus_grant` = 1, `core_stall` follows `core_ext_req`. `core_stall` is never 1 while `bus_grant` is 0.
- R7: `grant_hang` is 1 exactly when `bus_grant`, `go_mode` and `core_ext_req` are all 1.
- R8: Once the synchronized request has fallen, `bus_grant` drops on the next edge. The drivers are then re-enabled, and the stall and hang flag clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_async | input | 1 | Bus request from the outside master, asynchronous, active high |
| xfer_busy | input | 1 | High while a core external access is in progress |
| core_ext_req | input | 1 | Core needs an external access in this cycle |
| go_mode | input | 1 | 1 = core keeps running after grant, 0 = core halts while granted |
| bus_grant | output | 1 | Bus granted to the outside master |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Data bus drive enable |
| strobe_oe | output | STROBE_N | Per-strobe drive enables for the memory selects and read/write strobes |
| core_stall | output | 1 | Stall the core |
| grant_hang | output | 1 | Core waits for a bus that is granted away |

## Verification
The bench builds the arbiter with SYNC_STAGES = 3 and STROBE_N = 5. This shows that both the request latency and the strobe enable width follow their parameters, not fixed values of 2 and 7. A deeper chain widens the window in which a short request pulse or a fast withdrawal is still in flight. This exposes grant pulses of a single cycle and requests that arrive while an access is draining. The random stimulus holds the request for long runs and also toggles it quickly. It mixes the busy, core-request and mode inputs against those runs.

// File: rtl/bra_pkg.sv
package bra_pkg;
  typedef enum logic [1:0] {
    ARB_CORE  = 2'd0,
    ARB_DRAIN = 2'd1,
    ARB_HOST  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bra_sync.sv
module bra_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bra_fsm.sv
module bra_fsm
  import bra_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_s,
  input  logic       xfer_busy,
  output arb_state_e state
);
  arb_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ARB_CORE:  if (req_s) nxt = xfer_busy ? ARB_DRAIN : ARB_HOST;
      ARB_DRAIN: if (!req_s)         nxt = ARB_CORE;
                 else if (!xfer_busy) nxt = ARB_HOST;
      ARB_HOST:  if (!req_s) nxt = ARB_CORE;
      default:   nxt = ARB_CORE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ARB_CORE;
    else        state <= nxt;
endmodule

// File: rtl/bra_drive.sv
module bra_drive #(
  parameter int unsigned STROBE_N = 7
) (
  input  logic                granted,
  input  logic                go_mode,
  input  logic                core_ext_req,
  output logic                addr_oe,
  output logic                data_oe,
  output logic [STROBE_N-1:0] strobe_oe,
  output logic                core_stall,
  output logic                grant_hang
);
  assign addr_oe = ~granted;
  assign data_oe = ~granted;

  for (genvar i = 0; i < STROBE_N; i++) begin : g_strobe
    assign strobe_oe[i] = ~granted;
  end

  always_comb begin
    core_stall = 1'b0;
    grant_hang = 1'b0;
    if (granted) begin
      if (go_mode) begin
        core_stall = core_ext_req;
        grant_hang = core_ext_req;
      end else begin
        core_stall = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_req_arb.sv
module bus_req_arb
  import bra_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STROBE_N    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req_async,
  input  logic                xfer_busy,
  input  logic                core_ext_req,
  input  logic                go_mode,
  output logic                bus_grant,
  output logic                addr_oe,
  output logic                data_oe,
  output logic [STROBE_N-1:0] strobe_oe,
  output logic                core_stall,
  output logic                grant_hang
);
  logic       req_s;
  arb_state_e state;

  bra_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_req_async), .q(req_s)
  );

  bra_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .xfer_busy(xfer_busy), .state(state)
  );

  assign bus_grant = (state == ARB_HOST);

  bra_drive #(.STROBE_N(STROBE_N)) u_drive (
    .granted(bus_grant), .go_mode(go_mode), .core_ext_req(core_ext_req),
    .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe),
    .core_stall(core_stall), .grant_hang(grant_hang)
  );
endmodule

// File: rtl/bus_req_arb_chk.sv
module bus_req_arb_chk #(
  parameter int unsigned STROBE_N = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xfer_busy,
  input logic                core_ext_req,
  input logic                go_mode,
  input logic                bus_grant,
  input logic                addr_oe,
  input logic                data_oe,
  input logic [STROBE_N-1:0] strobe_oe,
  input logic                core_stall,
  input logic                grant_hang
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_reset_owner: assert (!bus_grant && !core_stall && !grant_hang && addr_oe && data_oe);

  a_r4_off_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (!addr_oe && !data_oe && strobe_oe == '0));

  a_r4_on_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> (addr_oe && data_oe && &strobe_oe));

  a_r5_halt_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !go_mode) |-> core_stall);

  a_r6_stall_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> bus_grant);

  a_r7_hang_cause: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hang |-> (bus_grant && go_mode && core_ext_req));

  a_r3_wait_for_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(!xfer_busy));

  a_r8_release_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> (!core_stall && !grant_hang));
endmodule

bind bus_req_arb bus_req_arb_chk #(.STROBE_N(STROBE_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_busy(xfer_busy), .core_ext_req(core_ext_req),
  .go_mode(go_mode), .bus_grant(bus_grant), .addr_oe(addr_oe), .data_oe(data_oe),
  .strobe_oe(strobe_oe), .core_stall(core_stall), .grant_hang(grant_hang)
);

// File: tb/sim_bus_req_arb.sv
module sim_bus_req_arb;
  localparam int unsigned SS = 3;
  localparam int unsigned SN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, busy = 1'b0, creq = 1'b0, go = 1'b0;
  logic bus_grant, addr_oe, data_oe, core_stall, grant_hang;
  logic [SN-1:0] strobe_oe;

  always #2.5 clk = ~clk;

  bus_req_arb #(.SYNC_STAGES(SS), .STROBE_N(SN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req_async(req), .xfer_busy(busy),
    .core_ext_req(creq), .go_mode(go), .bus_grant(bus_grant), .addr_oe(addr_oe),
    .data_oe(data_oe), .strobe_oe(strobe_oe), .core_stall(core_stall),
    .grant_hang(grant_hang)
  );

  int checks = 0;
  int fails = 0;

  // reference model: 0 core owns, 1 waiting for access, 2 granted
  logic [SS-1:0] m_sync = '0;
  int m_st = 0;

  task automatic model_step();
    int nst;
    nst = m_st;
    if (!rst_n) begin
      m_sync = '0; m_st = 0;
      return;
    end
    case (m_st)
      0: if (m_sync[SS-1]) nst = busy ? 1 : 2;
      1: if (!m_sync[SS-1]) nst = 0; else if (!busy) nst = 2;
      default: if (!m_sync[SS-1]) nst = 0;
    endcase
    m_st = nst;
    m_sync = {m_sync[SS-2:0], req};
  endtask

  function automatic logic exp_grant(); return m_st == 2; endfunction
  function automatic logic exp_stall(); return exp_grant() && (!go || creq); endfunction
  function automatic logic exp_hang();  return exp_grant() && go && creq; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic g;
    g = exp_grant();
    chk("R2 R3 R8 grant", 32'(bus_grant), 32'(g));
    chk("R4 drivers", {addr_oe, data_oe, strobe_oe}, (!g) ? {(SN+2){1'b1}} : '0);
    chk("R5 R6 stall", 32'(core_stall), 32'(exp_stall()));
    chk("R7 hang", 32'(grant_hang), 32'(exp_hang()));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin : watchdog
    #(5 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int lat;
    void'($urandom(32'h5eed_0042));
    req = 1'b1; busy = 1'b0; creq = 1'b1;
    repeat (4) begin
      cyc();
      chk("R1 reset grant", 32'(bus_grant), 32'd0);
      chk("R1 reset drivers", 32'(addr_oe && data_oe && &strobe_oe), 32'd1);
    end
    req = 1'b0; creq = 1'b0;
    rst_n = 1'b1;
    repeat (SS + 2) cyc();

    // R2 directed latency, idle bus, normal mode
    req = 1'b1; lat = 0;
    do begin cyc(); lat++; end while (!bus_grant && lat < 20);
    chk("R2 latency", 32'(lat), 32'(SS + 1));
    chk("R5 normal stall", 32'(core_stall), 32'd1);
    req = 1'b0;
    repeat (SS + 2) cyc();
    chk("R8 released", 32'(bus_grant), 32'd0);

    // R3 directed: access in progress delays grant
    busy = 1'b1; req = 1'b1;
    repeat (SS + 6) cyc();
    chk("R3 held off", 32'(bus_grant), 32'd0);
    chk("R3 no stall while draining", 32'(core_stall), 32'd0);
    busy = 1'b0;
    cyc();
    chk("R3 granted after idle", 32'(bus_grant), 32'd1);

    // R6 R7 directed go mode
    go = 1'b1; creq = 1'b0;
    cyc();
    chk("R6 go runs", 32'(core_stall), 32'd0);
    creq = 1'b1;
    cyc();
    chk("R7 hang raised", 32'(grant_hang), 32'd1);
    req = 1'b0;
    repeat (SS + 1) cyc();
    chk("R8 hang cleared", 32'(grant_hang), 32'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) req = ~req;
      busy = ($urandom_range(0, 2) == 0);
      creq = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 63) == 0) go = ~go;
      cyc();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule